// File: doc/BRIEF.md
# Three-Lane Green-Light Arbiter

This block picks which of three parallel traffic lanes shows green. One lane is the express lane and always wins when a car waits in it. The other two are the west lane and the east lane. When both of them have cars and the express lane is empty, an external toggle bit decides between them. The block does not keep its own rotation state.

The decision logic is combinational. A register stage with a synchronous active-high reset captures the three lamp outputs, so every input pattern appears at the lamps one clock later. The toggle signal comes from outside the block and is taken as given.

Top module: `lane_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, all three lamps read 0 (red) after that edge, whatever the sensors show.
- R2: When `car_x` is 1, `lamp_x` is 1 and `lamp_w`, `lamp_e` are 0 after the next edge.
- R3: When `car_x` is 0, `car_w` is 1 and `car_e` is 0, only `lamp_w` is 1 after the next edge.
- R4: When `car_x` is 0, `car_w` is 0 and `car_e` is 1, only `lamp_e` is 1 after the next edge.
- R5: When `car_x` is 0 and both `car_w` and `car_e` are 1, the toggle decides: `pick_w`=1 greens the west lane and `pick_w`=0 greens the east lane.
- R6: With no car present, all lamps are 0 after the next edge. `pick_w` has no effect in that case.
- R7: At most one lamp is 1 in any cycle.
- R8: Each lamp shows the input pattern sampled at the previous rising edge. The output latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| car_x | input | 1 | Express-lane car present (1 = car) |
| car_w | input | 1 | West-lane car present (1 = car) |
| car_e | input | 1 | East-lane car present (1 = car) |
| pick_w | input | 1 | Toggle: 1 favours west, 0 favours east |
| lamp_x | output | 1 | Express-lane lamp (1 = green) |
| lamp_w | output | 1 | West-lane lamp (1 = green) |
| lamp_e | output | 1 | East-lane lamp (1 = green) |

## Verification
Two functions can act in the same cycle: express-lane priority and the west/east toggle. The bench provokes this by raising all three sensors together with both toggle values. It checks that only the express lamp lights. A second overlap is reset asserted while cars wait. The bench drives sensor patterns during reset and expects all lamps red. After reset is released, it expects the one-cycle-delayed decision.

// File: rtl/lane_arb_pkg.sv
package lane_arb_pkg;

    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_X    = 2'd1,
        LANE_W    = 2'd2,
        LANE_E    = 2'd3
    } lane_t;

    typedef struct packed {
        logic car_x;
        logic car_w;
        logic car_e;
        logic pick_w;
    } sense_t;

    typedef struct packed {
        logic x;
        logic w;
        logic e;
    } lamps_t;

    function automatic lane_t choose_lane(input sense_t s);
        if (s.car_x)                  return LANE_X;
        else if (s.car_w && !s.car_e) return LANE_W;
        else if (!s.car_w && s.car_e) return LANE_E;
        else if (s.car_w && s.car_e)  return s.pick_w ? LANE_W : LANE_E;
        else                          return LANE_NONE;
    endfunction

    function automatic lamps_t lane_to_lamps(input lane_t l);
        lamps_t r;
        r.x = (l == LANE_X);
        r.w = (l == LANE_W);
        r.e = (l == LANE_E);
        return r;
    endfunction

endpackage

// File: rtl/lane_decide.sv
module lane_decide
    import lane_arb_pkg::*;
(
    input  sense_t sense,
    output lane_t  winner
);
    always_comb begin
        winner = choose_lane(sense);
    end
endmodule

// File: rtl/lamp_reg.sv
module lamp_reg
    import lane_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lane_t  winner,
    output lamps_t lamps
);
    lamps_t nxt;

    always_comb begin
        nxt = lane_to_lamps(winner);
    end

    always_ff @(posedge clk) begin
        if (rst) lamps <= '0;
        else     lamps <= nxt;
    end

    // R7: lamps mutually exclusive
    p_one_hot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lamps.x, lamps.w, lamps.e}));

    // R1: reset drives all red
    p_reset_red_r1: assert property (@(posedge clk)
        rst |=> (lamps == '0));
endmodule

// File: rtl/lane_arbiter.sv
module lane_arbiter
    import lane_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic car_x,
    input  logic car_w,
    input  logic car_e,
    input  logic pick_w,
    output logic lamp_x,
    output logic lamp_w,
    output logic lamp_e
);
    sense_t sense;
    lane_t  winner;
    lamps_t lamps;

    always_comb begin
        sense.car_x  = car_x;
        sense.car_w  = car_w;
        sense.car_e  = car_e;
        sense.pick_w = pick_w;
    end

    lane_decide u_decide (
        .sense  (sense),
        .winner (winner)
    );

    lamp_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .winner (winner),
        .lamps  (lamps)
    );

    assign lamp_x = lamps.x;
    assign lamp_w = lamps.w;
    assign lamp_e = lamps.e;

    // R2: express lane wins one cycle later
    p_express_wins_r2: assert property (@(posedge clk) disable iff (rst)
        car_x |=> (lamp_x && !lamp_w && !lamp_e));

    // R3: west alone
    p_west_alone_r3: assert property (@(posedge clk) disable iff (rst)
        (!car_x && car_w && !car_e) |=> (lamp_w && !lamp_x && !lamp_e));

    // R4: east alone
    p_east_alone_r4: assert property (@(posedge clk) disable iff (rst)
        (!car_x && !car_w && car_e) |=> (lamp_e && !lamp_x && !lamp_w));

    // R5: toggle decides contention
    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (!car_x && car_w && car_e) |=> (lamp_w == $past(pick_w) && lamp_e == !$past(pick_w)));

    // R6: no cars, all red
    p_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (!car_x && !car_w && !car_e) |=> (!lamp_x && !lamp_w && !lamp_e));
endmodule

// File: tb/sim_lane_arbiter.sv
module sim_lane_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_x = 0, car_w = 0, car_e = 0, pick_w = 0;
    logic lamp_x, lamp_w, lamp_e;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lane_arbiter u0 (
        .clk(clk), .rst(rst), .car_x(car_x), .car_w(car_w), .car_e(car_e),
        .pick_w(pick_w), .lamp_x(lamp_x), .lamp_w(lamp_w), .lamp_e(lamp_e)
    );

    function automatic logic [2:0] model(input logic x, input logic w,
                                         input logic e, input logic p);
        if (x)           return 3'b100;
        if (w && !e)     return 3'b010;
        if (!w && e)     return 3'b001;
        if (w && e)      return p ? 3'b010 : 3'b001;
        return 3'b000;
    endfunction

    function automatic string tag(input logic x, input logic w, input logic e);
        if (x)           return "R2";
        if (w && !e)     return "R3";
        if (!w && e)     return "R4";
        if (w && e)      return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        checks++;
        if ({lamp_x, lamp_w, lamp_e} !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req,
                     {lamp_x, lamp_w, lamp_e}, exp);
        end
    endtask

    task automatic apply(input logic [3:0] v, input string req);
        @(negedge clk);
        {car_x, car_w, car_e, pick_w} = v;
        @(negedge clk);
        check(req, model(v[3], v[2], v[1], v[0]));
        if ({lamp_x, lamp_w, lamp_e} != 3'b000) begin
            checks++;
            if ($countones({lamp_x, lamp_w, lamp_e}) != 1) begin
                failures++;
                $display("FAIL R7 actual=%b expected=one-hot", {lamp_x, lamp_w, lamp_e});
            end
        end
    endtask

    initial begin
        void'($urandom(32'd12345));
        // R1: reset with cars present
        {car_x, car_w, car_e, pick_w} = 4'b1111;
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        {car_x, car_w, car_e, pick_w} = 4'b0110;
        @(negedge clk);
        check("R1", 3'b000);
        rst = 0;
        // exhaustive sweep of all 16 patterns
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = i[3:0];
            apply(v, tag(v[3], v[2], v[1]));
        end
        // R5 contention both ways, and R2 overrides it
        apply(4'b0111, "R5");
        apply(4'b0110, "R5");
        apply(4'b1111, "R2");
        apply(4'b1110, "R2");
        // R6: pick_w toggling with no cars
        apply(4'b0001, "R6");
        apply(4'b0000, "R6");
        // R8: latency check: change input, sample before next edge
        @(negedge clk);
        {car_x, car_w, car_e, pick_w} = 4'b0100;
        @(negedge clk);
        {car_x, car_w, car_e, pick_w} = 4'b0010;
        #1 check("R8", 3'b010);
        @(negedge clk);
        check("R8", 3'b001);
        // random stimulus
        for (int k = 0; k < 200; k++) begin
            logic [3:0] v;
            v = 4'($urandom_range(0, 15));
            apply(v, tag(v[3], v[2], v[1]));
        end
        // R1: reset mid-run with traffic
        @(negedge clk);
        {car_x, car_w, car_e, pick_w} = 4'b1000;
        rst = 1;
        @(negedge clk);
        check("R1", 3'b000);
        rst = 0;
        @(negedge clk);
        check("R2", 3'b100);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule